// File: doc/BRIEF.md
# Macro-instruction reorder buffer

This block keeps the program order of architectural instructions in an out-of-order core. Each instruction gets one entry at the tail of a circular buffer when it is dispatched. The entry holds the instruction's full address and the physical register tags given to its result-producing micro-ops, with up to `SLOTS` tags per instruction. Micro-ops carry only the short entry index and their slot number. When a micro-op completes it reports that index and slot, and the block marks the slot as written.

Any micro-op may report a fault against its entry index. The fault is held in the entry and stays hidden until that entry becomes the oldest one. The head entry retires as soon as every slot it uses has been written. It also retires at once if it holds a fault. A faulting retirement presents the fault code together with the parent instruction's address and discards every younger entry. An instruction that produces no register result, such as a store, uses no slots and retires as soon as it reaches the head.

Top module: `mrob_top`

## Requirements
- R1: After reset the buffer is empty. `empty`=1, `full`=0, `retire_valid`=0, `flush`=0 and `alloc_idx`=0.
- R2: An allocation is taken when `alloc_valid` and `alloc_ready` are both high. It fills the entry numbered `alloc_idx`, which is the tail. The tail then moves to the next index modulo 2^IDX_W. `alloc_ready` is low while the buffer holds 2^IDX_W entries and during a flush cycle.
- R3: `empty` is high exactly when no entry is held, and `full` is high exactly when 2^IDX_W entries are held.
- R4: A writeback (`wb_valid`, `wb_idx`, `wb_slot`) marks slot `wb_slot` of entry `wb_idx` as written, counting from the next cycle. The head entry retires when no used slot is still unwritten. Bit k of `alloc_used` marks slot k as used.
- R5: An entry allocated with `alloc_used`=0 retires in the first cycle it is the head.
- R6: A younger entry that has completed never retires ahead of an older entry that is still incomplete.
- R7: A fault report marks the entry, and only the first code reported for that entry is kept. The entry retires as soon as it is the head, even if some of its slots are unwritten. It then shows `retire_exc`=1, `retire_code` set to the first code, and `retire_addr` set to the address recorded at allocation.
- R8: A faulting retirement raises `flush` in the same cycle. From the next cycle the buffer is empty, and the next allocation takes the index that follows the faulting entry.
- R9: A writeback or fault report aimed at an entry that is not held has no effect. A later allocation of that index starts clean.
- R10: At most one entry retires per cycle. A normal retirement shows the entry's address, used mask and tag vector on `retire_addr`, `retire_used` and `retire_tags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_valid | input | 1 | Request to allocate an entry |
| alloc_addr | input | ADDR_W | Address of the instruction |
| alloc_used | input | SLOTS | Mask of slots that will receive a result |
| alloc_tags | input | SLOTS*PTAG_W | Physical register tag per slot, slot 0 in the low bits |
| alloc_ready | output | 1 | Allocation can be taken this cycle |
| alloc_idx | output | IDX_W | Index the next allocation receives |
| wb_valid | input | 1 | Completion report |
| wb_idx | input | IDX_W | Entry of the completing micro-op |
| wb_slot | input | SLOT_W | Slot of the completing micro-op |
| exc_valid | input | 1 | Fault report |
| exc_idx | input | IDX_W | Entry of the faulting micro-op |
| exc_code | input | EXC_W | Fault code |
| retire_valid | output | 1 | The head entry retires this cycle |
| retire_addr | output | ADDR_W | Address of the retiring instruction |
| retire_used | output | SLOTS | Used mask of the retiring entry |
| retire_tags | output | SLOTS*PTAG_W | Tags of the retiring entry |
| retire_exc | output | 1 | The retiring entry carries a fault |
| retire_code | output | EXC_W | Held fault code, zero when there is no fault |
| flush | output | 1 | Younger entries are discarded this cycle |
| full | output | 1 | All entries are held |
| empty | output | 1 | No entry is held |

## Verification
On every cycle the assertions check the following. The head pointer advances by at most one. A flush always leaves the buffer empty. The tail stays put while the buffer is full. A normal retirement never leaves a used slot unwritten. A fault held by an entry stays in place with its code unchanged until the entry leaves. An entry that is not held never carries a fault.

Other behaviour can only be shown by the bench's scenarios. These include the program order of retirements, the addresses and tags that come out, keeping the first of two fault codes, the restart index after a flush, and a stale report having no effect on a later allocation. For these, the bench compares the outputs against a reference model.

// File: rtl/mrob_pkg.sv
package mrob_pkg;

  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_DONE  = 2'd1,
    RK_FAULT = 2'd2
  } retire_kind_e;

  // Pointers carry one extra wrap bit above the index bits.
  function automatic logic ptrs_full(input logic [31:0] head, input logic [31:0] tail,
                                     input int idx_w);
    return (head ^ tail) == (32'd1 << idx_w);
  endfunction

  function automatic logic ptrs_empty(input logic [31:0] head, input logic [31:0] tail);
    return head == tail;
  endfunction

  function automatic logic slots_pending(input logic [31:0] used, input logic [31:0] written);
    return |(used & ~written);
  endfunction

  function automatic retire_kind_e classify(input logic valid, input logic fault,
                                            input logic pending);
    if (!valid)       return RK_NONE;
    else if (fault)   return RK_FAULT;
    else if (!pending) return RK_DONE;
    else              return RK_NONE;
  endfunction

endpackage

// File: rtl/mrob_ptrs.sv
module mrob_ptrs
  import mrob_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic           pop,
  input  logic           flush,
  output logic [IDX_W:0] head,
  output logic [IDX_W:0] tail,
  output logic           full,
  output logic           empty
);

  logic [IDX_W:0] head_nx;

  assign head_nx = head + 1'b1;
  assign full    = ptrs_full(32'(head), 32'(tail), IDX_W);
  assign empty   = ptrs_empty(32'(head), 32'(tail));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (pop) head <= head_nx;
      if (flush)     tail <= head_nx;
      else if (push) tail <= tail + 1'b1;
    end
  end

  // R10
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (head == $past(head) || head == $past(head) + 1'b1));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> (tail == $past(tail)));

endmodule

// File: rtl/mrob_entry.sv
module mrob_entry #(
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 4,
  parameter int PTAG_W = 7,
  parameter int EXC_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_en,
  input  logic [ADDR_W-1:0]       alloc_addr,
  input  logic [SLOTS-1:0]        alloc_used,
  input  logic [SLOTS*PTAG_W-1:0] alloc_tags,
  input  logic [SLOTS-1:0]        wb_hit,
  input  logic                    exc_hit,
  input  logic [EXC_W-1:0]        exc_code,
  input  logic                    kill,
  output logic                    valid_q,
  output logic [ADDR_W-1:0]       addr_q,
  output logic [SLOTS-1:0]        used_q,
  output logic [SLOTS-1:0]        written_q,
  output logic [SLOTS*PTAG_W-1:0] tags_q,
  output logic                    exc_q,
  output logic [EXC_W-1:0]        code_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      addr_q    <= '0;
      used_q    <= '0;
      written_q <= '0;
      tags_q    <= '0;
      exc_q     <= 1'b0;
      code_q    <= '0;
    end else if (kill) begin
      valid_q <= 1'b0;
      exc_q   <= 1'b0;
    end else if (alloc_en) begin
      valid_q   <= 1'b1;
      addr_q    <= alloc_addr;
      used_q    <= alloc_used;
      written_q <= '0;
      tags_q    <= alloc_tags;
      exc_q     <= 1'b0;
      code_q    <= '0;
    end else if (valid_q) begin
      written_q <= written_q | wb_hit;
      if (exc_hit && !exc_q) begin
        exc_q  <= 1'b1;
        code_q <= exc_code;
      end
    end
  end

  // R7
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_q && !kill) |=> (exc_q && $stable(code_q)));

  // R9
  idle_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && !alloc_en) |=> !exc_q);

endmodule

// File: rtl/mrob_head_view.sv
module mrob_head_view
  import mrob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 4,
  parameter int PTAG_W = 7,
  parameter int EXC_W  = 4
) (
  input  logic [IDX_W-1:0]        head_idx,
  input  logic [DEPTH-1:0]        e_valid,
  input  logic [DEPTH-1:0]        e_exc,
  input  logic [ADDR_W-1:0]       e_addr    [DEPTH],
  input  logic [SLOTS-1:0]        e_used    [DEPTH],
  input  logic [SLOTS-1:0]        e_written [DEPTH],
  input  logic [SLOTS*PTAG_W-1:0] e_tags    [DEPTH],
  input  logic [EXC_W-1:0]        e_code    [DEPTH],
  output logic [ADDR_W-1:0]       h_addr,
  output logic [SLOTS-1:0]        h_used,
  output logic [SLOTS-1:0]        h_written,
  output logic [SLOTS*PTAG_W-1:0] h_tags,
  output logic [EXC_W-1:0]        h_code,
  output retire_kind_e            h_kind
);

  always_comb begin
    h_addr    = e_addr[head_idx];
    h_used    = e_used[head_idx];
    h_written = e_written[head_idx];
    h_tags    = e_tags[head_idx];
    h_code    = e_code[head_idx];
    h_kind    = classify(e_valid[head_idx], e_exc[head_idx],
                         slots_pending(32'(h_used), 32'(h_written)));
  end

endmodule

// File: rtl/mrob_top.sv
module mrob_top
  import mrob_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 4,
  parameter int PTAG_W = 7,
  parameter int EXC_W  = 4,
  localparam int DEPTH  = 1 << IDX_W,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_valid,
  input  logic [ADDR_W-1:0]       alloc_addr,
  input  logic [SLOTS-1:0]        alloc_used,
  input  logic [SLOTS*PTAG_W-1:0] alloc_tags,
  output logic                    alloc_ready,
  output logic [IDX_W-1:0]        alloc_idx,
  input  logic                    wb_valid,
  input  logic [IDX_W-1:0]        wb_idx,
  input  logic [SLOT_W-1:0]       wb_slot,
  input  logic                    exc_valid,
  input  logic [IDX_W-1:0]        exc_idx,
  input  logic [EXC_W-1:0]        exc_code,
  output logic                    retire_valid,
  output logic [ADDR_W-1:0]       retire_addr,
  output logic [SLOTS-1:0]        retire_used,
  output logic [SLOTS*PTAG_W-1:0] retire_tags,
  output logic                    retire_exc,
  output logic [EXC_W-1:0]        retire_code,
  output logic                    flush,
  output logic                    full,
  output logic                    empty
);

  logic [IDX_W:0]          head, tail;
  logic                    push;
  logic [IDX_W-1:0]        head_idx;
  logic [DEPTH-1:0]        e_valid, e_exc;
  logic [ADDR_W-1:0]       e_addr    [DEPTH];
  logic [SLOTS-1:0]        e_used    [DEPTH];
  logic [SLOTS-1:0]        e_written [DEPTH];
  logic [SLOTS*PTAG_W-1:0] e_tags    [DEPTH];
  logic [EXC_W-1:0]        e_code    [DEPTH];
  logic [SLOTS-1:0]        head_written;
  logic [EXC_W-1:0]        head_code;
  retire_kind_e            head_kind;

  assign head_idx     = head[IDX_W-1:0];
  assign alloc_idx    = tail[IDX_W-1:0];
  assign retire_valid = (head_kind != RK_NONE);
  assign retire_exc   = (head_kind == RK_FAULT);
  assign flush        = retire_exc;
  assign retire_code  = retire_exc ? head_code : '0;
  assign alloc_ready  = !full && !flush;
  assign push         = alloc_valid && alloc_ready;

  mrob_ptrs #(.IDX_W(IDX_W)) u_ptrs (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (retire_valid),
    .flush (flush),
    .head  (head),
    .tail  (tail),
    .full  (full),
    .empty (empty)
  );

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic             alloc_en_w, kill_w, exc_hit_w;
    logic [SLOTS-1:0] wb_hit_w;

    assign alloc_en_w = push && (alloc_idx == IDX_W'(e));
    assign kill_w     = flush || (retire_valid && head_idx == IDX_W'(e));
    assign exc_hit_w  = exc_valid && (exc_idx == IDX_W'(e));
    assign wb_hit_w   = (wb_valid && wb_idx == IDX_W'(e)) ? (SLOTS'(1) << wb_slot) : '0;

    mrob_entry #(
      .ADDR_W (ADDR_W),
      .SLOTS  (SLOTS),
      .PTAG_W (PTAG_W),
      .EXC_W  (EXC_W)
    ) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (alloc_en_w),
      .alloc_addr (alloc_addr),
      .alloc_used (alloc_used),
      .alloc_tags (alloc_tags),
      .wb_hit     (wb_hit_w),
      .exc_hit    (exc_hit_w),
      .exc_code   (exc_code),
      .kill       (kill_w),
      .valid_q    (e_valid[e]),
      .addr_q     (e_addr[e]),
      .used_q     (e_used[e]),
      .written_q  (e_written[e]),
      .tags_q     (e_tags[e]),
      .exc_q      (e_exc[e]),
      .code_q     (e_code[e])
    );
  end

  mrob_head_view #(
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W),
    .SLOTS  (SLOTS),
    .PTAG_W (PTAG_W),
    .EXC_W  (EXC_W)
  ) u_head_view (
    .head_idx  (head_idx),
    .e_valid   (e_valid),
    .e_exc     (e_exc),
    .e_addr    (e_addr),
    .e_used    (e_used),
    .e_written (e_written),
    .e_tags    (e_tags),
    .e_code    (e_code),
    .h_addr    (retire_addr),
    .h_used    (retire_used),
    .h_written (head_written),
    .h_tags    (retire_tags),
    .h_code    (head_code),
    .h_kind    (head_kind)
  );

  // R4
  done_all_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && !retire_exc) |-> ((retire_used & ~head_written) == '0));

  // R10
  retire_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> !empty);

endmodule

// File: tb/mrob_top_bench.sv
module mrob_top_bench;

  localparam int D   = 16;
  localparam int IW  = 4;
  localparam int SL  = 4;
  localparam int TW  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic          alloc_valid = 0;
  logic [31:0]   alloc_addr = 0;
  logic [SL-1:0] alloc_used = 0;
  logic [SL*TW-1:0] alloc_tags = 0;
  logic          alloc_ready;
  logic [IW-1:0] alloc_idx;
  logic          wb_valid = 0;
  logic [IW-1:0] wb_idx = 0;
  logic [1:0]    wb_slot = 0;
  logic          exc_valid = 0;
  logic [IW-1:0] exc_idx = 0;
  logic [3:0]    exc_code = 0;
  logic          retire_valid, retire_exc, flush, full, empty;
  logic [31:0]   retire_addr;
  logic [SL-1:0] retire_used;
  logic [SL*TW-1:0] retire_tags;
  logic [3:0]    retire_code;

  int total = 0;
  int bad = 0;

  // reference model
  bit            m_valid [D];
  logic [31:0]   m_addr  [D];
  logic [SL-1:0] m_used  [D];
  logic [SL-1:0] m_wr    [D];
  logic [SL*TW-1:0] m_tags [D];
  bit            m_exc   [D];
  logic [3:0]    m_code  [D];
  int m_head = 0;
  int m_tail = 0;

  always #10 clk = ~clk;

  mrob_top u_mrob_top (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_used(alloc_used),
    .alloc_tags(alloc_tags), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_slot(wb_slot),
    .exc_valid(exc_valid), .exc_idx(exc_idx), .exc_code(exc_code),
    .retire_valid(retire_valid), .retire_addr(retire_addr), .retire_used(retire_used),
    .retire_tags(retire_tags), .retire_exc(retire_exc), .retire_code(retire_code),
    .flush(flush), .full(full), .empty(empty)
  );

  function automatic int m_cnt();
    return (m_tail - m_head + 2*D) % (2*D);
  endfunction

  function automatic bit exp_ret();
    int h = m_head % D;
    return m_cnt() > 0 && m_valid[h] && (m_exc[h] || ((m_used[h] & ~m_wr[h]) == '0));
  endfunction

  function automatic bit exp_flush();
    return exp_ret() && m_exc[m_head % D];
  endfunction

  function automatic bit exp_ready();
    return m_cnt() < D && !exp_flush();
  endfunction

  task automatic chkv(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 0; wb_valid = 0; exc_valid = 0;
  endtask

  // Check outputs against the model, then advance the model across one edge.
  task automatic cycle();
    int h;
    bit r, f, push;
    #1;
    h = m_head % D;
    r = exp_ret();
    f = exp_flush();
    chkv("R3 empty flag", 64'(empty), 64'(m_cnt() == 0));
    chkv("R3 full flag", 64'(full), 64'(m_cnt() == D));
    chkv("R2 alloc_ready", 64'(alloc_ready), 64'(exp_ready()));
    chkv("R2 alloc_idx", 64'(alloc_idx), 64'(m_tail % D));
    chkv("R4 retire_valid", 64'(retire_valid), 64'(r));
    chkv("R8 flush", 64'(flush), 64'(f));
    if (r) begin
      chkv("R10 retire_addr", 64'(retire_addr), 64'(m_addr[h]));
      chkv("R7 retire_exc", 64'(retire_exc), 64'(m_exc[h]));
      if (m_exc[h]) chkv("R7 retire_code", 64'(retire_code), 64'(m_code[h]));
      else begin
        chkv("R10 retire_used", 64'(retire_used), 64'(m_used[h]));
        chkv("R10 retire_tags", 64'(retire_tags), 64'(retire_tags === m_tags[h] ? retire_tags : m_tags[h]));
      end
    end
    push = alloc_valid && exp_ready();
    if (wb_valid && m_valid[wb_idx]) m_wr[wb_idx] |= SL'(1) << wb_slot;
    if (exc_valid && m_valid[exc_idx] && !m_exc[exc_idx]) begin
      m_exc[exc_idx] = 1; m_code[exc_idx] = exc_code;
    end
    if (r) begin
      if (f) begin
        for (int i = 0; i < D; i++) begin m_valid[i] = 0; m_exc[i] = 0; end
      end else begin
        m_valid[h] = 0; m_exc[h] = 0;
      end
    end
    if (push) begin
      m_valid[m_tail % D] = 1; m_addr[m_tail % D] = alloc_addr;
      m_used[m_tail % D] = alloc_used; m_wr[m_tail % D] = '0;
      m_tags[m_tail % D] = alloc_tags; m_exc[m_tail % D] = 0; m_code[m_tail % D] = '0;
    end
    if (r) m_head = (m_head + 1) % (2*D);
    if (f) m_tail = m_head;
    else if (push) m_tail = (m_tail + 1) % (2*D);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] seen_code;
    logic [31:0] seen_addr;
    bit got;
    void'($urandom(32'd4711));
    for (int i = 0; i < D; i++) begin
      m_valid[i] = 0; m_exc[i] = 0; m_used[i] = 0; m_wr[i] = 0;
      m_addr[i] = 0; m_tags[i] = 0; m_code[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chkv("R1 empty after reset", 64'(empty), 1);
    chkv("R1 full after reset", 64'(full), 0);
    chkv("R1 retire after reset", 64'(retire_valid), 0);
    chkv("R1 flush after reset", 64'(flush), 0);
    chkv("R1 alloc_idx after reset", 64'(alloc_idx), 0);
    @(negedge clk);

    // fill the buffer, one used slot each
    for (int i = 0; i < D; i++) begin
      idle(); alloc_valid = 1; alloc_addr = 32'h1000 + 32'(4*i);
      alloc_used = 4'b0001; alloc_tags = 28'(i + 1);
      cycle();
    end
    idle(); alloc_valid = 1; alloc_addr = 32'hdead;
    #1;
    chkv("R2 refused when full", 64'(alloc_ready), 0);
    chkv("R3 full after filling", 64'(full), 1);
    cycle();
    // R6 younger entry completes first
    idle(); wb_valid = 1; wb_idx = 2; wb_slot = 0; cycle();
    idle(); #1;
    chkv("R6 head waits although younger done", 64'(retire_valid), 0);
    cycle();
    idle(); wb_valid = 1; wb_idx = 0; wb_slot = 0; cycle();
    idle(); wb_valid = 1; wb_idx = 1; wb_slot = 0; #1;
    chkv("R4 head retires once written", 64'(retire_valid), 1);
    chkv("R4 head address", 64'(retire_addr), 64'h1000);
    cycle();
    // R7 two faults on entry 5: the first code stays
    idle(); exc_valid = 1; exc_idx = 5; exc_code = 4'd3; cycle();
    idle(); exc_valid = 1; exc_idx = 5; exc_code = 4'd9; cycle();
    idle(); wb_valid = 1; wb_idx = 3; wb_slot = 0; cycle();
    idle(); wb_valid = 1; wb_idx = 4; wb_slot = 0; cycle();
    got = 0; seen_code = 0; seen_addr = 0;
    for (int k = 0; k < 10; k++) begin
      idle(); #1;
      if (retire_valid && retire_exc && !got) begin
        got = 1; seen_code = retire_code; seen_addr = retire_addr;
      end
      cycle();
    end
    chkv("R7 fault reached retirement", 64'(got), 1);
    chkv("R7 first code kept", 64'(seen_code), 3);
    chkv("R7 fault address", 64'(seen_addr), 64'h1014);
    #1;
    chkv("R8 empty after flush", 64'(empty), 1);
    chkv("R8 restart index", 64'(alloc_idx), 6);
    @(negedge clk);
    // R9 stale fault to an index not held, then allocate it
    idle(); exc_valid = 1; exc_idx = 6; exc_code = 4'd7;
    wb_valid = 1; wb_idx = 6; wb_slot = 1; cycle();
    idle(); alloc_valid = 1; alloc_addr = 32'h2000; alloc_used = 4'b0010; alloc_tags = 28'h55; cycle();
    idle(); #1;
    chkv("R9 stale reports ignored", 64'(retire_valid), 0);
    cycle();
    idle(); wb_valid = 1; wb_idx = 6; wb_slot = 1; cycle();
    idle(); #1;
    chkv("R9 clean entry retires without fault", 64'(retire_exc), 0);
    chkv("R9 clean entry retires", 64'(retire_valid), 1);
    cycle();
    // R5 entry with no result slots
    idle(); alloc_valid = 1; alloc_addr = 32'h3000; alloc_used = 4'b0000; cycle();
    idle(); #1;
    chkv("R5 no-result entry retires at head", 64'(retire_valid), 1);
    cycle();

    // constrained random phases
    for (int ph = 0; ph < 6; ph++) begin
      int ap = (ph % 2 == 0) ? 90 : 40;
      int wp = (ph % 2 == 0) ? 25 : 70;
      for (int n = 0; n < 600; n++) begin
        int c = m_cnt();
        idle();
        alloc_valid = ($urandom % 100) < ap;
        alloc_addr  = $urandom;
        alloc_used  = 4'($urandom);
        alloc_tags  = 28'($urandom);
        wb_valid    = ($urandom % 100) < wp;
        wb_idx      = (c > 0 && ($urandom % 8) != 0) ? 4'((m_head + ($urandom % c)) % D) : 4'($urandom);
        wb_slot     = 2'($urandom);
        exc_valid   = ($urandom % 40) == 0;
        exc_idx     = (c > 0) ? 4'((m_head + ($urandom % c)) % D) : 4'($urandom);
        exc_code    = 4'($urandom);
        cycle();
      end
    end

    idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule